// File: doc/BRIEF.md
# Beam-Gated PWM Generator with First-Pulse Suppression

This block drives one PWM line for a laser controller. A programmable period sets how many count steps make up one PWM period, and a level value sets where in the period the output goes high. The output is forced low at the start of every period. It goes high when the down-counter reaches the level, and it then stays high until the period ends, so the high time always sits at the end of the period. Each count step takes a fixed number of clock cycles, whatever the output does.

A beam-enable input gates the output. It is synchronized inside the block. When the beam is switched on after being off, the first pulse the generator would produce is withheld, so the laser does not fire a high-energy opening shot. Later pulses follow normally for as long as the beam stays on.

Software-side writes come through two strobed ports. A period write stops and restarts the generator. A level write goes into a one-entry holding register, and that value becomes active only at the next period boundary.

Top module: `laser_pwm_gate`

## Requirements
- R1: On synchronous reset `pwm_out` is low, the active level is 0, the period is RST_PERIOD (default 255) and suppression is armed. With `beam_en` held high from reset, the first period gives no pulse and the second gives a 2-cycle pulse; a period lasts 3*(255+1) = 768 cycles.
- R2: With STEP_CLKS = 3, a period programmed to P lasts 3*(P+1) clock cycles.
- R3: With level L <= P, the output is high for 3*L+2 consecutive cycles per period and falls exactly at the period boundary.
- R4: When the synchronized `beam_en` is low at the level match, the output stays low for that whole period.
- R5: Whenever the synchronized `beam_en` is low, suppression is armed. While it is armed, the first level match with the beam on leaves the output low and disarms it. The following periods pulse normally.
- R6: A level write does not change the period in progress. The held value becomes active at the next period boundary, a second write before that boundary replaces the first, and with no write pending the active level is kept.
- R7: A period write drives `pwm_out` low on the next cycle, discards any held level, keeps the active level and restarts from a fresh period of the new length.
- R8: A level greater than the period never produces a pulse. A level of 0 produces a 2-cycle pulse at the end of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| per_wr | input | 1 | Period write strobe, restarts the generator |
| per_data | input | CNT_W | New period value, in count steps minus one |
| lvl_wr | input | 1 | Level write strobe, loads the holding register |
| lvl_data | input | CNT_W | New level value |
| beam_en | input | 1 | Asynchronous beam-enable input |
| pwm_out | output | 1 | PWM output to the laser controller |

## Verification
The hardest case to reach from the ports is proving that exactly one pulse was withheld after a beam turn-on. The match has to land in a known period while the synchronizer delay is still settling. The bench gets there by holding the beam off, then issuing a period write and raising the beam on the same cycle. This places the first match at a fixed offset, and the bench counts rising edges over a window that spans exactly two matches. The boundary rule for level updates is reached by writing a new level just after a falling edge, which is the start of a period, and then measuring the pulse of the period still in progress.

// File: rtl/lpg_pkg.sv
`timescale 1ns/1ps
package lpg_pkg;
   // smallest legal step length: match evaluation and wrap must fall in different cycles
   localparam int LPG_MIN_STEP_CLKS = 2;
   localparam int LPG_MIN_SYNC      = 1;

   function automatic int lpg_ph_w(input int steps);
      return (steps > 2) ? $clog2(steps) : 1;
   endfunction
endpackage

// File: rtl/lpg_sync.sv
`timescale 1ns/1ps
module lpg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 1) begin : g_one
         logic s_q;
         always_ff @(posedge clk) begin
            if (rst) s_q <= 1'b0;
            else     s_q <= d;
         end
         assign q = s_q;
      end else begin : g_chain
         logic [STAGES-1:0] s_q;
         always_ff @(posedge clk) begin
            if (rst) s_q <= '0;
            else     s_q <= {s_q[STAGES-2:0], d};
         end
         assign q = s_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/lpg_timebase.sv
`timescale 1ns/1ps
module lpg_timebase
   import lpg_pkg::*;
#(
   parameter int          CNT_W      = 16,
   parameter int          STEP_CLKS  = 3,
   parameter logic [CNT_W-1:0] RST_PERIOD = 255
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             per_wr,
   input  logic [CNT_W-1:0] per_data,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] period,
   output logic             step_first,
   output logic             wrap
);
   localparam int PH_W = lpg_ph_w(STEP_CLKS);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(STEP_CLKS - 1);

   logic [PH_W-1:0] phase;
   logic            step_last;

   assign step_first = (phase == '0);
   assign step_last  = (phase == PH_LAST);
   assign wrap       = step_last && (cnt == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         period <= RST_PERIOD;
         cnt    <= RST_PERIOD;
         phase  <= '0;
      end else if (per_wr) begin
         period <= per_data;
         cnt    <= per_data;
         phase  <= '0;
      end else if (step_last) begin
         phase <= '0;
         cnt   <= wrap ? period : cnt - 1'b1;
      end else begin
         phase <= phase + 1'b1;
      end
   end
endmodule

// File: rtl/lpg_level.sv
`timescale 1ns/1ps
module lpg_level #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             per_wr,
   input  logic             lvl_wr,
   input  logic [CNT_W-1:0] lvl_data,
   input  logic             wrap,
   output logic [CNT_W-1:0] level
);
   logic [CNT_W-1:0] hold_q;
   logic             hold_v;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= '0;
         hold_v <= 1'b0;
      end else if (per_wr) begin
         hold_v <= 1'b0;
      end else if (lvl_wr) begin
         hold_q <= lvl_data;
         hold_v <= 1'b1;
      end else if (wrap) begin
         hold_v <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         level <= '0;
      else if (!per_wr && wrap && hold_v)
         level <= hold_q;
   end
endmodule

// File: rtl/laser_pwm_gate.sv
`timescale 1ns/1ps
module laser_pwm_gate
   import lpg_pkg::*;
#(
   parameter int          CNT_W       = 16,
   parameter int          STEP_CLKS   = 3,
   parameter int          SYNC_STAGES = 2,
   parameter logic [CNT_W-1:0] RST_PERIOD = 255
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             per_wr,
   input  logic [CNT_W-1:0] per_data,
   input  logic             lvl_wr,
   input  logic [CNT_W-1:0] lvl_data,
   input  logic             beam_en,
   output logic             pwm_out
);
   initial begin
      if (STEP_CLKS < LPG_MIN_STEP_CLKS)
         $fatal(1, "STEP_CLKS below minimum");
      if (SYNC_STAGES < LPG_MIN_SYNC)
         $fatal(1, "SYNC_STAGES below minimum");
      if (CNT_W < 2)
         $fatal(1, "CNT_W too small");
   end

   logic             en_s;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] level_q;
   logic             step_first;
   logic             wrap;
   logic             arm_q;
   logic             pwm_q;
   logic             match;

   lpg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (beam_en),
      .q   (en_s)
   );

   lpg_timebase #(
      .CNT_W      (CNT_W),
      .STEP_CLKS  (STEP_CLKS),
      .RST_PERIOD (RST_PERIOD)
   ) u_tb (
      .clk        (clk),
      .rst        (rst),
      .per_wr     (per_wr),
      .per_data   (per_data),
      .cnt        (cnt),
      .period     (per_q),
      .step_first (step_first),
      .wrap       (wrap)
   );

   lpg_level #(.CNT_W(CNT_W)) u_lvl (
      .clk      (clk),
      .rst      (rst),
      .per_wr   (per_wr),
      .lvl_wr   (lvl_wr),
      .lvl_data (lvl_data),
      .wrap     (wrap),
      .level    (level_q)
   );

   assign match = step_first && (cnt == level_q) && en_s;

   always_ff @(posedge clk) begin
      if (rst) begin
         pwm_q <= 1'b0;
         arm_q <= 1'b1;
      end else begin
         if (!en_s)
            arm_q <= 1'b1;
         else if (match && !per_wr)
            arm_q <= 1'b0;

         if (per_wr || wrap)
            pwm_q <= 1'b0;
         else if (match && !arm_q)
            pwm_q <= 1'b1;
      end
   end

   assign pwm_out = pwm_q;
endmodule

// File: rtl/laser_pwm_gate_chk.sv
`timescale 1ns/1ps
module laser_pwm_gate_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             per_wr,
   input logic             pwm_out,
   input logic             en_s,
   input logic             arm_q,
   input logic             wrap,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] per_q,
   input logic [CNT_W-1:0] level_q
);
   AST_RELOAD_PERIOD: assert property (@(posedge clk) disable iff (rst)
      (wrap && !per_wr) |=> (cnt == $past(per_q)));                        // R2
   AST_LOW_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
      wrap |=> !pwm_out);                                                  // R3
   AST_RISE_NEEDS_BEAM: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_out) |-> $past(en_s));                                     // R4
   AST_REARM_ON_OFF: assert property (@(posedge clk) disable iff (rst)
      !en_s |=> arm_q);                                                    // R5
   AST_RISE_NOT_ARMED: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_out) |-> !$past(arm_q));                                   // R5
   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wrap |=> $stable(level_q));                                         // R6
   AST_LOW_AFTER_PER_WR: assert property (@(posedge clk) disable iff (rst)
      per_wr |=> !pwm_out);                                                // R7
endmodule

bind laser_pwm_gate laser_pwm_gate_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .per_wr  (per_wr),
   .pwm_out (pwm_out),
   .en_s    (en_s),
   .arm_q   (arm_q),
   .wrap    (wrap),
   .cnt     (cnt),
   .per_q   (per_q),
   .level_q (level_q)
);

// File: tb/sim_laser_pwm_gate.sv
`timescale 1ns/1ps
module sim_laser_pwm_gate;
   localparam int W   = 16;
   localparam int LIM = 3000;
   localparam int NV  = 6;
   // period, level, expected high cycles, expected period cycles
   localparam int VEC [NV][4] = '{
      '{4, 1, 5, 15},
      '{6, 1, 5, 21},
      '{6, 3, 11, 21},
      '{10, 0, 2, 33},
      '{5, 5, 17, 18},
      '{8, 7, 23, 27}
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         per_wr = 1'b0;
   logic [W-1:0] per_data = '0;
   logic         lvl_wr = 1'b0;
   logic [W-1:0] lvl_data = '0;
   logic         beam_en = 1'b0;
   logic         pwm_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   laser_pwm_gate #(.CNT_W(W)) u0 (
      .clk      (clk),
      .rst      (rst),
      .per_wr   (per_wr),
      .per_data (per_data),
      .lvl_wr   (lvl_wr),
      .lvl_data (lvl_data),
      .beam_en  (beam_en),
      .pwm_out  (pwm_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_period(input int p);
      per_wr = 1'b1; per_data = W'(p);
      @(negedge clk);
      per_wr = 1'b0;
   endtask

   task automatic wr_level(input int l);
      lvl_wr = 1'b1; lvl_data = W'(l);
      @(negedge clk);
      lvl_wr = 1'b0;
   endtask

   // waits for the next rising edge, then measures high and full period
   task automatic measure(output int hi, output int per);
      int n;
      int lo;
      hi = -1; per = -1;
      n = 0;
      while (pwm_out && n < LIM) begin @(negedge clk); n++; end
      n = 0;
      while (!pwm_out && n < LIM) begin @(negedge clk); n++; end
      if (!pwm_out) return;
      hi = 0;
      while (pwm_out && hi < LIM) begin @(negedge clk); hi++; end
      lo = 0;
      while (!pwm_out && lo < LIM) begin @(negedge clk); lo++; end
      per = hi + lo;
   endtask

   task automatic count_high(input int cyc, output int highs, output int rises);
      logic prev;
      prev = pwm_out;
      highs = 0; rises = 0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         if (pwm_out) highs++;
         if (pwm_out && !prev) rises++;
         prev = pwm_out;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int hi, per, highs, rises;
      // R1: reset state
      beam_en = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 output low in reset", int'(pwm_out), 0);
      rst = 1'b0;
      count_high(760, highs, rises);
      chk("R1 first period suppressed", highs, 0);
      measure(hi, per);
      chk("R1 level zero pulse width", hi, 2);
      chk("R1 reset period length", per, 768);

      // R2 R3: table of period/level pairs
      for (int i = 0; i < NV; i++) begin
         wr_period(VEC[i][0]);
         wr_level(VEC[i][1]);
         measure(hi, per);
         measure(hi, per);
         measure(hi, per);
         chk($sformatf("R3 high time vec %0d", i), hi, VEC[i][2]);
         chk($sformatf("R2 period vec %0d", i), per, VEC[i][3]);
      end

      // R6: replace pending, boundary-only update, retention
      wr_period(6);
      wr_level(1);
      measure(hi, per); measure(hi, per);
      chk("R6 base level", hi, 5);
      wr_level(2);
      wr_level(4);
      measure(hi, per); measure(hi, per);
      chk("R6 second write replaces first", hi, 14);
      while (!pwm_out) @(negedge clk);
      while (pwm_out) @(negedge clk);
      wr_level(1);
      measure(hi, per);
      chk("R6 current period keeps old level", hi, 14);
      measure(hi, per);
      chk("R6 new level at boundary", hi, 5);
      measure(hi, per);
      chk("R6 level retained", hi, 5);

      // R7: period write drops output and discards pending level
      while (!pwm_out) @(negedge clk);
      wr_period(6);
      chk("R7 low after period write", int'(pwm_out), 0);
      wr_level(3);
      wr_period(6);
      measure(hi, per); measure(hi, per);
      chk("R7 pending discarded", hi, 5);
      chk("R7 period after restart", per, 21);

      // R8: level above period never pulses
      wr_period(4);
      wr_level(6);
      repeat (20) @(negedge clk);
      count_high(60, highs, rises);
      chk("R8 level above period", highs, 0);
      wr_level(1);
      repeat (40) @(negedge clk);

      // R4: beam off blocks pulses
      beam_en = 1'b0;
      count_high(60, highs, rises);
      chk("R4 beam off no pulse", highs, 0);

      // R5: first pulse after beam turn-on suppressed
      beam_en = 1'b1;
      wr_period(4);
      count_high(30, highs, rises);
      chk("R5 one pulse withheld", rises, 1);
      measure(hi, per);
      chk("R5 later pulses normal", hi, 5);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule